// File: doc/BRIEF.md
# Pivot-Based Spare Allocator for Memory Repair

This block decides how to spend a memory's spare rows and spare columns while a self-test is running, without keeping a failure bitmap or per-line fault counters. A test engine streams in the row and column address of every failing cell it finds. The block keeps at most one row/column address pair per spare, called pivots. Any later fault that lands on a stored row or column marks that line as essential. When the test finishes, essential rows get spare rows and essential columns get spare columns. Each pivot that was never marked essential is then covered with a leftover spare row, or with a spare column once the rows are gone.

A start pulse opens a collection window and clears all stored state. An end-of-test pulse closes the window. One cycle later the block presents a done flag, a repairable or irreparable verdict, and for every spare a valid flag and the address it replaces. If the pivot storage would overflow, the irreparable flag rises straight away, before the test ends.

Top module: `bisr_pivot_alloc`

## Requirements
- R1: After reset, and in the cycle after a start pulse, done, repairable, irreparable and every spare valid flag are low, and no pivots are held.
- R2: Faults are taken only after a start pulse and before an end-of-test pulse. A fault offered in the same cycle as end-of-test, or while results are shown, has no effect on any output.
- R3: A fault whose row matches no stored row pivot and whose column matches no stored column pivot is stored as a new pivot pair. A fault that matches any stored pivot adds no pair; it marks each matching row pivot and column pivot essential.
- R4: A new pair that would make more than SPR+SPC stored pairs sets the irreparable output in the next cycle, before end-of-test. The output stays high until the next start pulse.
- R5: Row pivots marked essential receive spare rows, taken from slot 0 upward in the order the pivots were stored.
- R6: Column pivots marked essential receive spare columns, taken from slot 0 upward in the order the pivots were stored.
- R7: If more row pivots are essential than SPR, or more column pivots are essential than SPC, the verdict is irreparable.
- R8: After the essential lines, each pivot that is neither row- nor column-essential is given, in storage order, the next free spare row. Once the rows are used up it gets the next free spare column. If neither is left, the verdict is irreparable.
- R9: Done rises in the cycle after a taken end-of-test pulse and holds until the next start. Repairable equals done with irreparable low.
- R10: While irreparable is high, all spare valid flags are low.
- R11: Within each spare kind, the valid flags are always filled from slot 0 upward with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse: clear state and open the collection window |
| test_end_i | input | 1 | Pulse: close the window and allocate spares |
| flt_vld_i | input | 1 | A failing cell is reported this cycle |
| flt_row_i | input | ROW_W | Row address of the failing cell |
| flt_col_i | input | COL_W | Column address of the failing cell |
| done_o | output | 1 | Results are valid |
| repair_ok_o | output | 1 | Done and all faults are covered |
| irrep_o | output | 1 | Memory cannot be repaired (early on overflow) |
| row_sp_vld_o | output | SPR | Per spare row: in use |
| row_sp_addr_o | output | SPR*ROW_W | Row address per spare row, slot s at bits s*ROW_W upward |
| col_sp_vld_o | output | SPC | Per spare column: in use |
| col_sp_addr_o | output | SPC*COL_W | Column address per spare column, slot s at bits s*COL_W upward |

## Verification
A missed essential mark shows up at done as a spare spent on the wrong kind of line, or as a wrong verdict. A pivot stored twice shows up the same way, one cycle after end-of-test. A broken overflow counter is visible earlier: the irreparable flag rises, or fails to rise, in the cycle right after the offending fault. Randomised fault sets drawn from a small address space force frequent row and column matches, so essential marking, storage order and orthogonal fallback are all compared slot by slot against a bench model.

// File: rtl/bisr_alloc_pkg.sv
package bisr_alloc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_RESULT  = 2'd2
  } alloc_state_e;
endpackage

// File: rtl/bisr_rst_sync.sv
module bisr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bisr_pivot_store.sv
module bisr_pivot_store #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int NPIV  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       acc_i,
  input  logic [ROW_W-1:0]           row_i,
  input  logic [COL_W-1:0]           col_i,
  output logic [NPIV-1:0]            piv_vld_o,
  output logic [NPIV-1:0][ROW_W-1:0] piv_row_o,
  output logic [NPIV-1:0][COL_W-1:0] piv_col_o,
  output logic [NPIV-1:0]            row_ess_o,
  output logic [NPIV-1:0]            col_ess_o,
  output logic                       any_hit_o,
  output logic                       ovf_o
);
  logic [NPIV-1:0]            vld_q, vld_d;
  logic [NPIV-1:0][ROW_W-1:0] row_q, row_d;
  logic [NPIV-1:0][COL_W-1:0] col_q, col_d;
  logic [NPIV-1:0]            ress_q, ress_d;
  logic [NPIV-1:0]            cess_q, cess_d;
  logic                       ovf_q, ovf_d;
  logic [NPIV-1:0]            row_hit, col_hit;
  logic                       full;

  // per-pivot comparators against the incoming fault
  for (genvar g = 0; g < NPIV; g++) begin : g_cmp
    assign row_hit[g] = vld_q[g] && (row_q[g] == row_i);
    assign col_hit[g] = vld_q[g] && (col_q[g] == col_i);
  end

  assign any_hit_o = |(row_hit | col_hit);
  assign full      = &vld_q;   // pivots fill from index 0 upward

  always_comb begin
    logic placed;
    vld_d  = vld_q;
    row_d  = row_q;
    col_d  = col_q;
    ress_d = ress_q;
    cess_d = cess_q;
    ovf_d  = ovf_q;
    placed = 1'b0;
    if (clr_i) begin
      vld_d  = '0;
      row_d  = '0;
      col_d  = '0;
      ress_d = '0;
      cess_d = '0;
      ovf_d  = 1'b0;
    end else if (acc_i && !ovf_q) begin
      if (any_hit_o) begin
        ress_d = ress_q | row_hit;
        cess_d = cess_q | col_hit;
      end else if (full) begin
        ovf_d = 1'b1;
      end else begin
        for (int i = 0; i < NPIV; i++) begin
          if (!vld_q[i] && !placed) begin
            vld_d[i] = 1'b1;
            row_d[i] = row_i;
            col_d[i] = col_i;
            placed   = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      row_q  <= '0;
      col_q  <= '0;
      ress_q <= '0;
      cess_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      row_q  <= row_d;
      col_q  <= col_d;
      ress_q <= ress_d;
      cess_q <= cess_d;
      ovf_q  <= ovf_d;
    end
  end

  assign piv_vld_o = vld_q;
  assign piv_row_o = row_q;
  assign piv_col_o = col_q;
  assign row_ess_o = ress_q;
  assign col_ess_o = cess_q;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/bisr_spare_alloc.sv
module bisr_spare_alloc #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int SPR   = 2,
  parameter int SPC   = 2,
  parameter int NPIV  = SPR + SPC
) (
  input  logic [NPIV-1:0]            piv_vld_i,
  input  logic [NPIV-1:0][ROW_W-1:0] piv_row_i,
  input  logic [NPIV-1:0][COL_W-1:0] piv_col_i,
  input  logic [NPIV-1:0]            row_ess_i,
  input  logic [NPIV-1:0]            col_ess_i,
  output logic [SPR-1:0]             row_vld_o,
  output logic [SPR-1:0][ROW_W-1:0]  row_addr_o,
  output logic [SPC-1:0]             col_vld_o,
  output logic [SPC-1:0][COL_W-1:0]  col_addr_o,
  output logic                       fail_o
);
  always_comb begin
    int rc;
    int cc;
    rc         = 0;
    cc         = 0;
    fail_o     = 1'b0;
    row_vld_o  = '0;
    row_addr_o = '0;
    col_vld_o  = '0;
    col_addr_o = '0;
    // pass 1: essential rows
    for (int i = 0; i < NPIV; i++) begin
      if (piv_vld_i[i] && row_ess_i[i]) begin
        if (rc >= SPR) fail_o = 1'b1;
        else begin
          for (int s = 0; s < SPR; s++) begin
            if (s == rc) begin
              row_vld_o[s]  = 1'b1;
              row_addr_o[s] = piv_row_i[i];
            end
          end
          rc = rc + 1;
        end
      end
    end
    // pass 2: essential columns
    for (int i = 0; i < NPIV; i++) begin
      if (piv_vld_i[i] && col_ess_i[i]) begin
        if (cc >= SPC) fail_o = 1'b1;
        else begin
          for (int s = 0; s < SPC; s++) begin
            if (s == cc) begin
              col_vld_o[s]  = 1'b1;
              col_addr_o[s] = piv_col_i[i];
            end
          end
          cc = cc + 1;
        end
      end
    end
    // pass 3: orthogonal pivots, rows first then columns
    for (int i = 0; i < NPIV; i++) begin
      if (piv_vld_i[i] && !row_ess_i[i] && !col_ess_i[i]) begin
        if (rc < SPR) begin
          for (int s = 0; s < SPR; s++) begin
            if (s == rc) begin
              row_vld_o[s]  = 1'b1;
              row_addr_o[s] = piv_row_i[i];
            end
          end
          rc = rc + 1;
        end else if (cc < SPC) begin
          for (int s = 0; s < SPC; s++) begin
            if (s == cc) begin
              col_vld_o[s]  = 1'b1;
              col_addr_o[s] = piv_col_i[i];
            end
          end
          cc = cc + 1;
        end else begin
          fail_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bisr_pivot_alloc.sv
module bisr_pivot_alloc
  import bisr_alloc_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int SPR   = 2,
  parameter int SPC   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 test_end_i,
  input  logic                 flt_vld_i,
  input  logic [ROW_W-1:0]     flt_row_i,
  input  logic [COL_W-1:0]     flt_col_i,
  output logic                 done_o,
  output logic                 repair_ok_o,
  output logic                 irrep_o,
  output logic [SPR-1:0]       row_sp_vld_o,
  output logic [SPR*ROW_W-1:0] row_sp_addr_o,
  output logic [SPC-1:0]       col_sp_vld_o,
  output logic [SPC*COL_W-1:0] col_sp_addr_o
);
  localparam int NPIV = SPR + SPC;

  logic                       rst_n_s;
  alloc_state_e               state_q, state_d;
  logic                       coll, acc, capture, any_hit, ovf;
  logic [NPIV-1:0]            piv_vld, row_ess, col_ess;
  logic [NPIV-1:0][ROW_W-1:0] piv_row;
  logic [NPIV-1:0][COL_W-1:0] piv_col;
  logic [SPR-1:0]             a_rvld;
  logic [SPR-1:0][ROW_W-1:0]  a_raddr;
  logic [SPC-1:0]             a_cvld;
  logic [SPC-1:0][COL_W-1:0]  a_caddr;
  logic                       a_fail;

  logic                       fail_q, fail_d;
  logic [SPR-1:0]             rvld_q, rvld_d;
  logic [SPR-1:0][ROW_W-1:0]  raddr_q, raddr_d;
  logic [SPC-1:0]             cvld_q, cvld_d;
  logic [SPC-1:0][COL_W-1:0]  caddr_q, caddr_d;

  bisr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign coll    = (state_q == ST_COLLECT);
  assign acc     = coll && flt_vld_i && !test_end_i && !start_i;
  assign capture = coll && test_end_i && !start_i;

  bisr_pivot_store #(.ROW_W(ROW_W), .COL_W(COL_W), .NPIV(NPIV)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr_i     (start_i),
    .acc_i     (acc),
    .row_i     (flt_row_i),
    .col_i     (flt_col_i),
    .piv_vld_o (piv_vld),
    .piv_row_o (piv_row),
    .piv_col_o (piv_col),
    .row_ess_o (row_ess),
    .col_ess_o (col_ess),
    .any_hit_o (any_hit),
    .ovf_o     (ovf)
  );

  bisr_spare_alloc #(.ROW_W(ROW_W), .COL_W(COL_W), .SPR(SPR), .SPC(SPC), .NPIV(NPIV)) u_alloc (
    .piv_vld_i  (piv_vld),
    .piv_row_i  (piv_row),
    .piv_col_i  (piv_col),
    .row_ess_i  (row_ess),
    .col_ess_i  (col_ess),
    .row_vld_o  (a_rvld),
    .row_addr_o (a_raddr),
    .col_vld_o  (a_cvld),
    .col_addr_o (a_caddr),
    .fail_o     (a_fail)
  );

  // next-state and result capture
  always_comb begin
    state_d = state_q;
    fail_d  = fail_q;
    rvld_d  = rvld_q;
    raddr_d = raddr_q;
    cvld_d  = cvld_q;
    caddr_d = caddr_q;
    if (start_i) begin
      state_d = ST_COLLECT;
      fail_d  = 1'b0;
      rvld_d  = '0;
      raddr_d = '0;
      cvld_d  = '0;
      caddr_d = '0;
    end else if (capture) begin
      state_d = ST_RESULT;
      fail_d  = a_fail | ovf;
      if (!(a_fail | ovf)) begin
        rvld_d  = a_rvld;
        raddr_d = a_raddr;
        cvld_d  = a_cvld;
        caddr_d = a_caddr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      fail_q  <= 1'b0;
      rvld_q  <= '0;
      raddr_q <= '0;
      cvld_q  <= '0;
      caddr_q <= '0;
    end else begin
      state_q <= state_d;
      fail_q  <= fail_d;
      rvld_q  <= rvld_d;
      raddr_q <= raddr_d;
      cvld_q  <= cvld_d;
      caddr_q <= caddr_d;
    end
  end

  assign done_o        = (state_q == ST_RESULT);
  assign irrep_o       = ovf | fail_q;
  assign repair_ok_o   = done_o && !irrep_o;
  assign row_sp_vld_o  = rvld_q;
  assign row_sp_addr_o = raddr_q;
  assign col_sp_vld_o  = cvld_q;
  assign col_sp_addr_o = caddr_q;
endmodule

// File: rtl/bisr_pivot_alloc_chk.sv
module bisr_pivot_alloc_chk #(
  parameter int SPR  = 2,
  parameter int SPC  = 2,
  parameter int NPIV = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            test_end_i,
  input logic            coll,
  input logic            acc,
  input logic            any_hit,
  input logic [NPIV-1:0] piv_vld,
  input logic            done_o,
  input logic            repair_ok_o,
  input logic            irrep_o,
  input logic [SPR-1:0]  row_sp_vld_o,
  input logic [SPC-1:0]  col_sp_vld_o
);
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !irrep_o && row_sp_vld_o == '0 && col_sp_vld_o == '0 && piv_vld == '0));

  a_r2_no_store_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (!coll && !start_i) |=> $stable(piv_vld));

  a_r3_hit_adds_none: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && any_hit) |=> $stable(piv_vld));

  a_r4_irrep_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irrep_o && !start_i) |=> irrep_o);

  a_r9_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && test_end_i && !start_i) |=> done_o);

  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  a_r9_ok_means_done: assert property (@(posedge clk) disable iff (!rst_n)
    repair_ok_o |-> (done_o && !irrep_o));

  a_r10_irrep_no_spares: assert property (@(posedge clk) disable iff (!rst_n)
    irrep_o |-> (row_sp_vld_o == '0 && col_sp_vld_o == '0));

  a_r11_row_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sp_vld_o & (row_sp_vld_o + SPR'(1))) == '0);

  a_r11_col_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (col_sp_vld_o & (col_sp_vld_o + SPC'(1))) == '0);
endmodule

bind bisr_pivot_alloc bisr_pivot_alloc_chk #(.SPR(SPR), .SPC(SPC), .NPIV(NPIV)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .test_end_i   (test_end_i),
  .coll         (coll),
  .acc          (acc),
  .any_hit      (any_hit),
  .piv_vld      (piv_vld),
  .done_o       (done_o),
  .repair_ok_o  (repair_ok_o),
  .irrep_o      (irrep_o),
  .row_sp_vld_o (row_sp_vld_o),
  .col_sp_vld_o (col_sp_vld_o)
);

// File: tb/bisr_pivot_alloc_tb_top.sv
`timescale 1ns/1ps
module bisr_pivot_alloc_tb_top;
  localparam int RW = 8;
  localparam int CW = 8;
  localparam int SPR = 2;
  localparam int SPC = 2;
  localparam int NP = SPR + SPC;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, test_end_i, flt_vld_i;
  logic [RW-1:0] flt_row_i;
  logic [CW-1:0] flt_col_i;
  logic done_o, repair_ok_o, irrep_o;
  logic [SPR-1:0] row_sp_vld_o;
  logic [SPR*RW-1:0] row_sp_addr_o;
  logic [SPC-1:0] col_sp_vld_o;
  logic [SPC*CW-1:0] col_sp_addr_o;

  always #4 clk = ~clk;

  bisr_pivot_alloc #(.ROW_W(RW), .COL_W(CW), .SPR(SPR), .SPC(SPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .test_end_i(test_end_i),
    .flt_vld_i(flt_vld_i), .flt_row_i(flt_row_i), .flt_col_i(flt_col_i),
    .done_o(done_o), .repair_ok_o(repair_ok_o), .irrep_o(irrep_o),
    .row_sp_vld_o(row_sp_vld_o), .row_sp_addr_o(row_sp_addr_o),
    .col_sp_vld_o(col_sp_vld_o), .col_sp_addr_o(col_sp_addr_o));

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // fault list for one case
  int f_n;
  logic [RW-1:0] f_row [16];
  logic [CW-1:0] f_col [16];

  // bench model
  int m_n;
  bit m_ovf;
  logic [RW-1:0] m_row [NP];
  logic [CW-1:0] m_col [NP];
  bit m_re [NP];
  bit m_ce [NP];
  bit e_fail;
  bit [SPR-1:0] e_rv;
  bit [SPC-1:0] e_cv;
  logic [RW-1:0] e_ra [SPR];
  logic [CW-1:0] e_ca [SPC];

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_clear();
    m_n = 0; m_ovf = 0;
    for (int i = 0; i < NP; i++) begin m_re[i] = 0; m_ce[i] = 0; m_row[i] = '0; m_col[i] = '0; end
  endtask

  task automatic m_fault(logic [RW-1:0] r, logic [CW-1:0] c);
    bit hit;
    hit = 0;
    if (m_ovf) return;
    for (int i = 0; i < m_n; i++) begin
      if (m_row[i] == r) begin m_re[i] = 1; hit = 1; end
      if (m_col[i] == c) begin m_ce[i] = 1; hit = 1; end
    end
    if (!hit) begin
      if (m_n == NP) m_ovf = 1;
      else begin m_row[m_n] = r; m_col[m_n] = c; m_n++; end
    end
  endtask

  task automatic m_alloc();
    int rc, cc;
    rc = 0; cc = 0; e_fail = m_ovf; e_rv = '0; e_cv = '0;
    for (int s = 0; s < SPR; s++) e_ra[s] = '0;
    for (int s = 0; s < SPC; s++) e_ca[s] = '0;
    for (int i = 0; i < m_n; i++)
      if (m_re[i]) begin
        if (rc >= SPR) e_fail = 1; else begin e_rv[rc] = 1; e_ra[rc] = m_row[i]; rc++; end
      end
    for (int i = 0; i < m_n; i++)
      if (m_ce[i]) begin
        if (cc >= SPC) e_fail = 1; else begin e_cv[cc] = 1; e_ca[cc] = m_col[i]; cc++; end
      end
    for (int i = 0; i < m_n; i++)
      if (!m_re[i] && !m_ce[i]) begin
        if (rc < SPR) begin e_rv[rc] = 1; e_ra[rc] = m_row[i]; rc++; end
        else if (cc < SPC) begin e_cv[cc] = 1; e_ca[cc] = m_col[i]; cc++; end
        else e_fail = 1;
      end
    if (e_fail) begin e_rv = '0; e_cv = '0; end
  endtask

  task automatic compare_result(string req);
    check(done_o == 1'b1, "R9 done after end", done_o, 1);
    check(irrep_o == e_fail, "R7 irreparable verdict", irrep_o, e_fail);
    check(repair_ok_o == !e_fail, "R9 repairable verdict", repair_ok_o, !e_fail);
    check(row_sp_vld_o == e_rv, {req, " spare row valid"}, row_sp_vld_o, e_rv);
    check(col_sp_vld_o == e_cv, {req, " spare col valid"}, col_sp_vld_o, e_cv);
    for (int s = 0; s < SPR; s++)
      if (e_rv[s]) check(row_sp_addr_o[s*RW +: RW] == e_ra[s], {req, " spare row addr"},
                         row_sp_addr_o[s*RW +: RW], e_ra[s]);
    for (int s = 0; s < SPC; s++)
      if (e_cv[s]) check(col_sp_addr_o[s*CW +: CW] == e_ca[s], {req, " spare col addr"},
                         col_sp_addr_o[s*CW +: CW], e_ca[s]);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    m_clear();
  endtask

  task automatic apply_case(string req);
    pulse_start();
    for (int k = 0; k < f_n; k++) begin
      flt_vld_i = 1'b1; flt_row_i = f_row[k]; flt_col_i = f_col[k];
      @(negedge clk);
      m_fault(f_row[k], f_col[k]);
      check(irrep_o == m_ovf, "R4 early irreparable", irrep_o, m_ovf);
      check(done_o == 1'b0, "R9 no done before end", done_o, 0);
    end
    flt_vld_i = 1'b0;
    test_end_i = 1'b1;
    @(negedge clk);
    test_end_i = 1'b0;
    m_alloc();
    compare_result(req);
  endtask

  task automatic set_f(int k, int r, int c);
    f_row[k] = RW'(r); f_col[k] = CW'(c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 0; test_end_i = 0; flt_vld_i = 0; flt_row_i = '0; flt_col_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(done_o == 0 && repair_ok_o == 0 && irrep_o == 0, "R1 reset flags",
          {done_o, repair_ok_o, irrep_o}, 0);
    check(row_sp_vld_o == 0 && col_sp_vld_o == 0, "R1 reset spares",
          {row_sp_vld_o, col_sp_vld_o}, 0);

    // R8 single orthogonal fault takes a spare row
    f_n = 1; set_f(0, 5, 7); apply_case("R8");
    // R5 essential row
    f_n = 3; set_f(0, 1, 1); set_f(1, 1, 2); set_f(2, 1, 3); apply_case("R5");
    // R6 essential column
    f_n = 3; set_f(0, 2, 9); set_f(1, 3, 9); set_f(2, 4, 9); apply_case("R6");
    // R3 repeated fault adds no pivot, marks both lines
    f_n = 3; set_f(0, 3, 3); set_f(1, 3, 3); set_f(2, 3, 3); apply_case("R3");
    // R8 rows used by essentials, orthogonal falls to a column
    f_n = 5; set_f(0, 1, 1); set_f(1, 1, 2); set_f(2, 2, 3); set_f(3, 2, 4); set_f(4, 5, 5);
    apply_case("R8");
    // R7 three essential rows with two spare rows
    f_n = 6; set_f(0, 1, 10); set_f(1, 1, 11); set_f(2, 2, 20); set_f(3, 2, 21);
    set_f(4, 3, 30); set_f(5, 3, 31); apply_case("R7");
    check(irrep_o == 1'b1, "R10 irreparable with spares cleared", irrep_o, 1);

    // R1 start clears after irreparable
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(done_o == 0 && irrep_o == 0 && repair_ok_o == 0, "R1 start clears flags",
          {done_o, irrep_o, repair_ok_o}, 0);
    check(row_sp_vld_o == 0 && col_sp_vld_o == 0, "R1 start clears spares",
          {row_sp_vld_o, col_sp_vld_o}, 0);

    // R4 five orthogonal faults overflow the pivots
    f_n = 5; for (int k = 0; k < 5; k++) set_f(k, k, k + 40); apply_case("R4");

    // R2 fault in the same cycle as end-of-test is ignored
    pulse_start();
    flt_vld_i = 1'b1; flt_row_i = 8'd6; flt_col_i = 8'd6; test_end_i = 1'b1;
    @(negedge clk);
    flt_vld_i = 1'b0; test_end_i = 1'b0;
    m_alloc();
    compare_result("R2");

    // R2 faults while results are shown change nothing
    f_n = 2; set_f(0, 7, 8); set_f(1, 9, 10); apply_case("R2");
    for (int k = 0; k < 6; k++) begin
      flt_vld_i = 1'b1; flt_row_i = 8'd7; flt_col_i = CW'(k);
      @(negedge clk);
    end
    flt_vld_i = 1'b0;
    @(negedge clk);
    compare_result("R2");

    // randomised fault sets in a small address space
    for (int t = 0; t < 60; t++) begin
      f_n = 1 + int'($urandom % 7);
      for (int k = 0; k < f_n; k++) set_f(k, int'($urandom % 6), int'($urandom % 6));
      apply_case((t % 2 == 0) ? "R5" : "R6");
      check((row_sp_vld_o & (row_sp_vld_o + 2'd1)) == 0, "R11 row slots packed", row_sp_vld_o, 0);
      check((col_sp_vld_o & (col_sp_vld_o + 2'd1)) == 0, "R11 col slots packed", col_sp_vld_o, 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule